// File: doc/BRIEF.md
# Per-Instruction Clock Class Selector with Timing-Error Replay

This controller sits between a delay-class predictor and the execute stage of a pipeline. For every instruction that enters execute, it receives a predicted delay class and registers a clock-class code. The external clock generator uses that code to pick the execute period. The controller also reports the period, in picoseconds, that the code stands for. With the default three classes, code 0 maps to 1800 ps, code 1 to 2600 ps, and code 2 to the worst-case 4000 ps.

Each execute result is captured twice: once at the shortened edge and once at a delayed point that is always safe at worst-case timing. When the two captures differ, a timing violation has occurred. The controller then pulses a flush and enters a replay. In replay it holds the clock class at worst case and ignores new predictions. It waits out the refill penalty of the fetch, decode, predict and execute stages, and it leaves replay only when the re-run instruction retires. An instruction predicted slower than it really is still retires normally, and only costs time. Two counters track retired instructions and replays, so that speedup can be estimated.

Top module: `clk_class_replay_ctrl`

## Requirements
- R1: While reset is high and in the cycle after reset, the outputs hold their reset values: `clk_sel` = 2 (worst case), `period_ps` = 4000, `flush`, `commit` and `replay_busy` = 0, and both counters = 0.
- R2: A prediction with `pred_valid`=1 and class code c < 3 is accepted when the controller is not in replay and no violation is detected in the same cycle. In the next cycle, `clk_sel` = c and `period_ps` = 1800, 2600 or 4000 for c = 0, 1 or 2.
- R3: In a cycle with no valid prediction, `clk_sel` becomes 2 (4000 ps) in the next cycle.
- R4: A result with `ex_valid`=1 and equal captures, outside replay, gives a one-cycle `commit` pulse in the next cycle and adds one to `commit_cnt`. It gives no `flush`.
- R5: A result with `ex_valid`=1 and differing captures, outside replay, gives a one-cycle `flush` pulse in the next cycle. It adds one to `replay_cnt` and raises `replay_busy` from that cycle on. `flush` and `commit` are never high together.
- R6: While `replay_busy` is high, `clk_sel` is 2, and valid predictions have no effect on it.
- R7: After a violation, results presented in the next 4 cycles are ignored and produce no commit. The first result after that retires the replayed instruction with a `commit` pulse, whether or not its captures match. `replay_busy` is low in the cycle after that commit.
- R8: A prediction that arrives in the same cycle as a detected violation is dropped, and `clk_sel` is 2 in the next cycle.
- R9: A class code of 3 or more is treated as the worst case: `clk_sel` = 2 and `period_ps` = 4000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Predicted class is valid this cycle |
| pred_class | input | 2 | Predicted delay class code |
| ex_valid | input | 1 | Execute result captures are valid this cycle |
| samp_fast | input | 32 | Result captured at the shortened edge |
| samp_safe | input | 32 | Result captured at the worst-case-safe point |
| clk_sel | output | 2 | Clock class code for the execute cycle |
| period_ps | output | 13 | Execute period for `clk_sel`, in picoseconds |
| flush | output | 1 | One-cycle flush and replay request |
| commit | output | 1 | One-cycle retire pulse |
| replay_busy | output | 1 | Replay in progress |
| commit_cnt | output | 16 | Count of retired instructions |
| replay_cnt | output | 16 | Count of replays |

## Verification
A violating result can arrive in the same cycle as the next instruction's prediction. The controller must then drop the prediction and start the replay, so the outcome depends on which of the two wins. The bench drives a mismatching capture pair together with a fast class code. It expects a flush pulse, the worst-case code, and no commit on the next cycle. It also drives matching results and fast predictions during every cycle of the replay window, and expects that they leave the class code and the retire stream untouched.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int unsigned WORST_PS = 4000;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } replay_st_e;

    typedef struct packed {
        logic valid;
        logic viol;
    } ex_chk_t;

    // Upper delay bound of a class; the top index is always the worst case.
    function automatic int unsigned class_period_ps(int unsigned n, int unsigned idx);
        int unsigned r;
        if (idx + 1 >= n) begin
            r = WORST_PS;
        end else begin
            case (n)
                2:       r = 2200;
                3:       r = (idx == 0) ? 1800 : 2600;
                4:       r = 1000 * (idx + 1);
                default: r = (WORST_PS * (idx + 1)) / n;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ccr_sample_cmp.sv
module ccr_sample_cmp
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              ex_valid,
    input  logic [DATA_W-1:0] samp_fast,
    input  logic [DATA_W-1:0] samp_safe,
    output ex_chk_t           chk
);
    always_comb begin
        chk.valid = ex_valid;
        chk.viol  = ex_valid && (samp_fast != samp_safe);
    end
endmodule

// File: rtl/ccr_replay_fsm.sv
module ccr_replay_fsm
    import ccr_pkg::*;
#(
    parameter int PENALTY = 4,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ex_chk_t          chk,
    output logic             take_pred,
    output logic             busy,
    output logic             flush,
    output logic             commit,
    output logic [CNT_W-1:0] commit_cnt,
    output logic [CNT_W-1:0] replay_cnt
);
    localparam int WAIT_W = (PENALTY > 1) ? $clog2(PENALTY + 1) : 1;

    replay_st_e        st, st_n;
    logic [WAIT_W-1:0] wcnt, wcnt_n;
    logic              flush_n, commit_n;

    always_comb begin
        st_n     = st;
        wcnt_n   = wcnt;
        flush_n  = 1'b0;
        commit_n = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (chk.valid) begin
                    if (chk.viol) begin
                        st_n    = ST_WAIT;
                        wcnt_n  = WAIT_W'(PENALTY - 1);
                        flush_n = 1'b1;
                    end else begin
                        commit_n = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (wcnt == '0) st_n = ST_EXEC;
                else            wcnt_n = wcnt - WAIT_W'(1);
            end
            ST_EXEC: begin
                if (chk.valid) begin
                    commit_n = 1'b1;
                    st_n     = ST_RUN;
                end
            end
            default: st_n = ST_RUN;
        endcase
    end

    assign take_pred = (st == ST_RUN) && !chk.viol;
    assign busy      = (st != ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_RUN;
            wcnt       <= '0;
            flush      <= 1'b0;
            commit     <= 1'b0;
            commit_cnt <= '0;
            replay_cnt <= '0;
        end else begin
            st     <= st_n;
            wcnt   <= wcnt_n;
            flush  <= flush_n;
            commit <= commit_n;
            if (commit_n) commit_cnt <= commit_cnt + CNT_W'(1);
            if (flush_n)  replay_cnt <= replay_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ccr_class_sel.sv
module ccr_class_sel
    import ccr_pkg::*;
#(
    parameter int NUM_CLASSES = 3,
    parameter int CLS_W       = 2,
    parameter int PERIOD_W    = 13
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pred_valid,
    input  logic [CLS_W-1:0]    pred_class,
    input  logic                take_pred,
    output logic [CLS_W-1:0]    clk_sel,
    output logic [PERIOD_W-1:0] period_ps
);
    localparam logic [CLS_W-1:0] WORST = CLS_W'(NUM_CLASSES - 1);

    logic [CLS_W-1:0] clamped, sel_n;

    assign clamped = (int'(pred_class) >= NUM_CLASSES) ? WORST : pred_class;
    assign sel_n   = (pred_valid && take_pred) ? clamped : WORST;

    always_ff @(posedge clk) begin
        if (rst) clk_sel <= WORST;
        else     clk_sel <= sel_n;
    end

    assign period_ps = PERIOD_W'(class_period_ps(NUM_CLASSES, int'(clk_sel)));
endmodule

// File: rtl/clk_class_replay_ctrl.sv
module clk_class_replay_ctrl
    import ccr_pkg::*;
#(
    parameter int NUM_CLASSES = 3,
    parameter int DATA_W      = 32,
    parameter int PENALTY     = 4,
    parameter int CNT_W       = 16,
    parameter int PERIOD_W    = 13,
    localparam int CLS_W      = (NUM_CLASSES > 2) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pred_valid,
    input  logic [CLS_W-1:0]    pred_class,
    input  logic                ex_valid,
    input  logic [DATA_W-1:0]   samp_fast,
    input  logic [DATA_W-1:0]   samp_safe,
    output logic [CLS_W-1:0]    clk_sel,
    output logic [PERIOD_W-1:0] period_ps,
    output logic                flush,
    output logic                commit,
    output logic                replay_busy,
    output logic [CNT_W-1:0]    commit_cnt,
    output logic [CNT_W-1:0]    replay_cnt
);
    ex_chk_t chk;
    logic    take_pred;

    ccr_sample_cmp #(.DATA_W(DATA_W)) u_cmp (
        .ex_valid (ex_valid),
        .samp_fast(samp_fast),
        .samp_safe(samp_safe),
        .chk      (chk)
    );

    ccr_replay_fsm #(.PENALTY(PENALTY), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .chk       (chk),
        .take_pred (take_pred),
        .busy      (replay_busy),
        .flush     (flush),
        .commit    (commit),
        .commit_cnt(commit_cnt),
        .replay_cnt(replay_cnt)
    );

    ccr_class_sel #(.NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W), .PERIOD_W(PERIOD_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .pred_valid(pred_valid),
        .pred_class(pred_class),
        .take_pred (take_pred),
        .clk_sel   (clk_sel),
        .period_ps (period_ps)
    );
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
    parameter int NUM_CLASSES = 3,
    parameter int DATA_W      = 32,
    localparam int CLS_W      = (NUM_CLASSES > 2) ? $clog2(NUM_CLASSES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              pred_valid,
    input logic [CLS_W-1:0]  pred_class,
    input logic              ex_valid,
    input logic [DATA_W-1:0] samp_fast,
    input logic [DATA_W-1:0] samp_safe,
    input logic [CLS_W-1:0]  clk_sel,
    input logic              flush,
    input logic              commit,
    input logic              replay_busy
);
    localparam logic [CLS_W-1:0] WORST = CLS_W'(NUM_CLASSES - 1);

    logic mism;
    assign mism = ex_valid && (samp_fast != samp_safe);

    assert_pred_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && !replay_busy && !mism && (int'(pred_class) < NUM_CLASSES))
        |=> (clk_sel == $past(pred_class)));

    assert_commit_on_match_R4: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !mism && !replay_busy) |=> (commit && !flush));

    assert_flush_on_mismatch_R5: assert property (@(posedge clk) disable iff (rst)
        (mism && !replay_busy) |=> (flush && replay_busy));

    assert_flush_commit_excl_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush, commit}));

    assert_worst_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        replay_busy |-> (clk_sel == WORST));

    assert_no_retire_after_flush_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!commit && replay_busy));

    assert_viol_drops_pred_R8: assert property (@(posedge clk) disable iff (rst)
        (mism && !replay_busy) |=> (clk_sel == WORST));
endmodule

bind clk_class_replay_ctrl ccr_checker #(.NUM_CLASSES(NUM_CLASSES), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pred_valid (pred_valid),
    .pred_class (pred_class),
    .ex_valid   (ex_valid),
    .samp_fast  (samp_fast),
    .samp_safe  (samp_safe),
    .clk_sel    (clk_sel),
    .flush      (flush),
    .commit     (commit),
    .replay_busy(replay_busy)
);

// File: tb/clk_class_replay_ctrl_tb.sv
module clk_class_replay_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pred_valid = 1'b0;
    logic [1:0]  pred_class = '0;
    logic        ex_valid = 1'b0;
    logic [31:0] samp_fast = '0;
    logic [31:0] samp_safe = '0;
    logic [1:0]  clk_sel;
    logic [12:0] period_ps;
    logic        flush, commit, replay_busy;
    logic [15:0] commit_cnt, replay_cnt;

    int checks = 0;
    int errors = 0;
    int exp_q[$];   // 1 = commit expected, 2 = flush expected

    always #10 clk = ~clk;

    clk_class_replay_ctrl u_dut (
        .clk(clk), .rst(rst),
        .pred_valid(pred_valid), .pred_class(pred_class),
        .ex_valid(ex_valid), .samp_fast(samp_fast), .samp_safe(samp_safe),
        .clk_sel(clk_sel), .period_ps(period_ps),
        .flush(flush), .commit(commit), .replay_busy(replay_busy),
        .commit_cnt(commit_cnt), .replay_cnt(replay_cnt)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus from a negedge; return at the next negedge.
    task automatic drive(input logic pv, input logic [1:0] pc, input logic ev,
                         input logic [31:0] f, input logic [31:0] s, input int expect_ev);
        pred_valid = pv;
        pred_class = pc;
        ex_valid   = ev;
        samp_fast  = f;
        samp_safe  = s;
        if (expect_ev != 0) exp_q.push_back(expect_ev);
        @(negedge clk);
    endtask

    // Scoreboard monitor: every retire or flush event must match the queue head.
    always @(negedge clk) begin
        if (!rst && (flush || commit)) begin
            int act;
            act = flush ? 2 : 1;
            if (exp_q.size() == 0) begin
                chk("R4/R5/R7 unexpected event", act, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk("R4/R5/R7 event order", act, e);
            end
            chk("R5 flush/commit exclusive", int'(flush && commit), 0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 clk_sel", clk_sel, 2);
        chk("R1 period", period_ps, 4000);
        chk("R1 flush", flush, 0);
        chk("R1 busy", replay_busy, 0);
        chk("R1 commit_cnt", commit_cnt, 0);
        chk("R1 replay_cnt", replay_cnt, 0);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 0);
        chk("R1 clk_sel after release", clk_sel, 2);
        chk("R1 commit after release", commit, 0);

        // R2 accepted predictions and their periods
        drive(1, 0, 0, 0, 0, 0);
        chk("R2 class0 sel", clk_sel, 0);
        chk("R2 class0 period", period_ps, 1800);
        drive(1, 1, 0, 0, 0, 0);
        chk("R2 class1 sel", clk_sel, 1);
        chk("R2 class1 period", period_ps, 2600);
        drive(1, 2, 0, 0, 0, 0);
        chk("R2 class2 period", period_ps, 4000);
        drive(1, 0, 0, 0, 0, 0);
        chk("R2 class0 again", clk_sel, 0);
        // R3 no prediction
        drive(0, 0, 0, 0, 0, 0);
        chk("R3 idle worst", clk_sel, 2);
        // R9 out-of-range code
        drive(1, 3, 0, 0, 0, 0);
        chk("R9 code3 sel", clk_sel, 2);
        chk("R9 code3 period", period_ps, 4000);

        // R4 matching result commits
        drive(1, 1, 1, 32'hA5A5_0001, 32'hA5A5_0001, 1);
        chk("R4 commit pulse", commit, 1);
        chk("R4 no flush", flush, 0);
        chk("R4 commit_cnt", commit_cnt, 1);
        chk("R2 sel alongside commit", clk_sel, 1);
        drive(0, 0, 1, 32'h0, 32'h0, 1);
        chk("R4 commit_cnt two", commit_cnt, 2);

        // R5 + R8 violation with a same-cycle fast prediction
        drive(1, 0, 1, 32'h1234_5678, 32'h1234_5679, 2);
        chk("R5 flush pulse", flush, 1);
        chk("R5 busy", replay_busy, 1);
        chk("R5 replay_cnt", replay_cnt, 1);
        chk("R8 prediction dropped", clk_sel, 2);
        chk("R5 no commit", commit, 0);

        // R6 + R7 penalty window: results and predictions ignored
        for (int i = 0; i < 4; i++) begin
            drive(1, 0, 1, 32'h5, 32'h5, 0);
            chk("R6 worst while busy", clk_sel, 2);
            chk("R7 still busy", replay_busy, 1);
            chk("R7 ignored result", commit, 0);
            chk("R5 flush single", flush, 0);
        end
        // R7 replayed instruction retires even with differing captures
        drive(1, 0, 1, 32'h7, 32'h8, 1);
        chk("R7 replay retire", commit, 1);
        chk("R7 busy cleared", replay_busy, 0);
        chk("R7 commit_cnt", commit_cnt, 3);
        chk("R7 replay_cnt unchanged", replay_cnt, 1);
        chk("R6 pred at retire ignored", clk_sel, 2);
        drive(1, 1, 0, 0, 0, 0);
        chk("R2 accepted after replay", clk_sel, 1);

        // R7 replay waits beyond the penalty for the re-run result
        drive(0, 0, 1, 32'hFF, 32'h00, 2);
        chk("R5 second replay_cnt", replay_cnt, 2);
        for (int i = 0; i < 7; i++) begin
            drive(1, 1, 0, 0, 0, 0);
            chk("R6 long replay worst", clk_sel, 2);
            chk("R7 long replay busy", replay_busy, 1);
        end
        drive(0, 0, 1, 32'h9, 32'h9, 1);
        chk("R7 late retire", commit, 1);
        chk("R7 late busy cleared", replay_busy, 0);
        chk("R7 commit_cnt late", commit_cnt, 4);
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        chk("R4/R5/R7 scoreboard drained", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule